// File: doc/BRIEF.md
# Register-Bus Decode and Width-Adapting Interconnect

This block joins one register-bus master to several slaves that may have different data widths. The master raises `m_sel` with an address, a direction flag and write data, then holds them until an acknowledge comes back. The interconnect compares the upper address bits against each slave's region and raises that slave's select. The direction flag goes to every slave unchanged. The write data and the slave-local address go to every slave after per-slave adaptation. The acknowledge, interrupt and read-data returns of all slaves are merged by OR onto the master side.

A slave narrower than the master bus sees only the low byte lanes. Its registers land on natural master-word boundaries, so its address is rescaled from master words into slave units. A slave in another clock domain can be marked asynchronous. Its acknowledge and interrupt then cross two master-clock flops before they are merged. An access that falls outside every region is answered by an internal responder, which acknowledges with zero data so the master never waits forever. Region bases, region sizes, slave widths and the asynchronous marks are parameters. Elaboration rejects overlapping regions, misaligned bases and any slave wider than the master bus.

Top module: `regbus_xbar`

## Requirements
- R1: `s_sel[i]` is high in the same cycle exactly when `m_sel` is high and `m_addr` lies in `[base_i, base_i + 2^szl_i)`. At most one select is high, and all are low while `m_sel` is low.
- R2: While `m_sel` is high and no region matches, `m_dtack` rises one clock edge later with `m_rdata` zero. It falls one clock edge after `m_sel` falls.
- R3: `m_rdata` is the bitwise OR of all slaves' read data. Bits at and above each slave's width are forced to 0 before merging.
- R4: Slave `i` receives `m_wdata` on its low `width_i` bits, with the upper bits driven 0. `s_read` equals `m_read` in the same cycle.
- R5: The slave address is `((m_addr - base_i) >> log2(MW/8)) << log2(width_i/8)`. On a 32-bit master bus, an 8-bit slave's bit 0 follows master bit 2 and a 16-bit slave's bit 1 follows master bit 2.
- R6: A synchronous slave's `s_dtack` appears on `m_dtack` in the same cycle.
- R7: For a slave marked asynchronous, `s_dtack` and `s_irq` reach `m_dtack` and `m_irq` on the second master clock edge after they change.
- R8: `m_irq` is the OR of all slaves' interrupt returns. Synchronous slaves appear in the same cycle.
- R9: While `rst_n` is low, `m_dtack` and `m_irq` are 0 even if an asynchronous slave holds its returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| m_sel | input | 1 | Master cycle in progress |
| m_read | input | 1 | 1 = read, 0 = write |
| m_addr | input | AW | Master byte address |
| m_wdata | input | MW | Master write data |
| m_rdata | output | MW | Merged read data to master |
| m_dtack | output | 1 | Merged acknowledge to master |
| m_irq | output | 1 | Merged interrupt to master |
| s_sel | output | NS | One select per slave |
| s_read | output | 1 | Broadcast direction flag |
| s_addr | output | NS*SAW | Per-slave rescaled address, slave i at bits [i*SAW +: SAW] |
| s_wdata | output | NS*MW | Per-slave lane-masked write data, slave i at [i*MW +: MW] |
| s_rdata | input | NS*MW | Per-slave read data, slave i at [i*MW +: MW] |
| s_dtack | input | NS | Per-slave acknowledge |
| s_irq | input | NS | Per-slave interrupt |

## Verification
Some properties are checked on every cycle: the selects stay one-hot and are gated by the master select, the internal responder acknowledges one edge after an unmatched access, a synchronous slave's acknowledge always reaches the master, and the upper write lanes of narrow slaves stay zero. Other behaviour can only be shown by the bench's scenarios. These cover the exact address rescaling for each slave width, the masking of junk on the upper read lanes, the two-edge delay through the asynchronous return path in both directions, and the region edges, including the first byte past a region and an unmapped gap.

// File: rtl/regbus_xbar_pkg.sv
package regbus_xbar_pkg;

  localparam int unsigned BYTE_BITS = 8;

  // legal slave width: power of two, at least one byte, not above master
  function automatic bit width_ok(int unsigned sdw, int unsigned mw);
    return (sdw >= BYTE_BITS) && (sdw <= mw) && ((sdw & (sdw - 1)) == 0);
  endfunction

  function automatic bit base_aligned(longint unsigned b, int unsigned l);
    longint unsigned m;
    m = (64'd1 << l) - 64'd1;
    return (b & m) == 64'd0;
  endfunction

  function automatic bit spans_overlap(longint unsigned b0, int unsigned l0,
                                       longint unsigned b1, int unsigned l1);
    longint unsigned e0;
    longint unsigned e1;
    e0 = b0 + (64'd1 << l0);
    e1 = b1 + (64'd1 << l1);
    return (b0 < e1) && (b1 < e0);
  endfunction

endpackage

// File: rtl/regbus_xbar_resync.sv
module regbus_xbar_resync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st1_q, st2_q;
  logic [W-1:0] st1_d, st2_d;
  logic         adv_en;

  always_comb begin
    adv_en = 1'b1;
    st1_d  = d;
    st2_d  = st1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else if (adv_en) begin
      st1_q <= st1_d;
      st2_q <= st2_d;
    end
  end

  assign q = st2_q;

endmodule

// File: rtl/regbus_xbar_decode.sv
module regbus_xbar_decode #(
  parameter int                NS       = 3,
  parameter int                AW       = 16,
  parameter logic [NS*AW-1:0]  SLV_BASE = '0,
  parameter logic [NS*8-1:0]   SLV_SZL  = '0
) (
  input  logic          m_sel,
  input  logic [AW-1:0] m_addr,
  output logic [NS-1:0] hit,
  output logic          miss
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < NS; i++) begin : g_slot
    localparam int            SZL     = int'(SLV_SZL[i*8 +: 8]);
    localparam logic [AW-1:0] BASE    = SLV_BASE[i*AW +: AW];
    localparam logic [AW-1:0] HI_MASK = ~((ONE << SZL) - ONE);
    assign hit[i] = m_sel && ((m_addr & HI_MASK) == BASE);
  end

  assign miss = m_sel && (hit == '0);

endmodule

// File: rtl/regbus_xbar_lane.sv
module regbus_xbar_lane #(
  parameter int AW  = 16,
  parameter int MW  = 32,
  parameter int SAW = 8,
  parameter int SZL = 6,
  parameter int SDW = 32
) (
  input  logic [AW-1:0]  m_addr,
  input  logic [MW-1:0]  m_wdata,
  input  logic [MW-1:0]  raw_rdata,
  output logic [SAW-1:0] s_addr,
  output logic [MW-1:0]  s_wdata,
  output logic [MW-1:0]  lane_rdata
);

  localparam int            MSH      = $clog2(MW / 8);
  localparam int            SSH      = $clog2(SDW / 8);
  localparam logic [AW-1:0] A_ONE    = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] OFF_MASK = (A_ONE << SZL) - A_ONE;
  localparam logic [MW-1:0] D_ONE    = {{(MW-1){1'b0}}, 1'b1};
  localparam logic [MW-1:0] LANES    = (SDW >= MW) ? {MW{1'b1}}
                                                   : ((D_ONE << SDW) - D_ONE);

  logic [AW-1:0] offset, word_idx, unit_addr;

  always_comb begin
    offset     = m_addr & OFF_MASK;
    word_idx   = offset >> MSH;
    unit_addr  = word_idx << SSH;
    s_addr     = unit_addr[SAW-1:0];
    s_wdata    = m_wdata & LANES;
    lane_rdata = raw_rdata & LANES;
  end

endmodule

// File: rtl/regbus_xbar.sv
module regbus_xbar
  import regbus_xbar_pkg::*;
#(
  parameter int               NS        = 3,
  parameter int               AW        = 16,
  parameter int               MW        = 32,
  parameter int               SAW       = 8,
  parameter logic [NS*AW-1:0] SLV_BASE  = {16'h0200, 16'h0100, 16'h0000},
  parameter logic [NS*8-1:0]  SLV_SZL   = {8'd6, 8'd6, 8'd6},
  parameter logic [NS*8-1:0]  SLV_DW    = {8'd16, 8'd8, 8'd32},
  parameter logic [NS-1:0]    SLV_ASYNC = 3'b100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_sel,
  input  logic             m_read,
  input  logic [AW-1:0]    m_addr,
  input  logic [MW-1:0]    m_wdata,
  output logic [MW-1:0]    m_rdata,
  output logic             m_dtack,
  output logic             m_irq,
  output logic [NS-1:0]    s_sel,
  output logic             s_read,
  output logic [NS*SAW-1:0] s_addr,
  output logic [NS*MW-1:0] s_wdata,
  input  logic [NS*MW-1:0] s_rdata,
  input  logic [NS-1:0]    s_dtack,
  input  logic [NS-1:0]    s_irq
);

  // ---------------- elaboration-time configuration check ----------------
  function automatic bit cfg_legal();
    bit ok;
    ok = width_ok(MW, MW) && (SAW <= AW);
    for (int i = 0; i < NS; i++) begin
      if (!width_ok(int'(SLV_DW[i*8 +: 8]), MW)) ok = 1'b0;
      if (int'(SLV_SZL[i*8 +: 8]) >= AW) ok = 1'b0;
      if (!base_aligned(longint'(SLV_BASE[i*AW +: AW]), int'(SLV_SZL[i*8 +: 8])))
        ok = 1'b0;
      for (int j = i + 1; j < NS; j++) begin
        if (spans_overlap(longint'(SLV_BASE[i*AW +: AW]), int'(SLV_SZL[i*8 +: 8]),
                          longint'(SLV_BASE[j*AW +: AW]), int'(SLV_SZL[j*8 +: 8])))
          ok = 1'b0;
      end
    end
    return ok;
  endfunction

  localparam bit CFG_OK = cfg_legal();

  if (!CFG_OK) begin : g_cfg_bad
    $error("regbus_xbar: overlapping, misaligned or over-wide slave configuration");
  end

  // ---------------- reset: asynchronous assert, synchronous release -------
  logic rst_ok;

  regbus_xbar_resync #(.W(1)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_ok)
  );

  // ---------------- address decode ----------------------------------------
  logic miss;

  regbus_xbar_decode #(
    .NS       (NS),
    .AW       (AW),
    .SLV_BASE (SLV_BASE),
    .SLV_SZL  (SLV_SZL)
  ) u_decode (
    .m_sel  (m_sel),
    .m_addr (m_addr),
    .hit    (s_sel),
    .miss   (miss)
  );

  assign s_read = m_read;

  // ---------------- per-slave adaptation and return path ------------------
  logic [NS*MW-1:0] lane_rdata;
  logic [NS-1:0]    ret_dtack;
  logic [NS-1:0]    ret_irq;

  for (genvar i = 0; i < NS; i++) begin : g_slv
    regbus_xbar_lane #(
      .AW  (AW),
      .MW  (MW),
      .SAW (SAW),
      .SZL (int'(SLV_SZL[i*8 +: 8])),
      .SDW (int'(SLV_DW[i*8 +: 8]))
    ) u_lane (
      .m_addr     (m_addr),
      .m_wdata    (m_wdata),
      .raw_rdata  (s_rdata[i*MW +: MW]),
      .s_addr     (s_addr[i*SAW +: SAW]),
      .s_wdata    (s_wdata[i*MW +: MW]),
      .lane_rdata (lane_rdata[i*MW +: MW])
    );

    if (SLV_ASYNC[i]) begin : g_hard
      logic [1:0] hq;
      regbus_xbar_resync #(.W(2)) u_ret_sync (
        .clk   (clk),
        .rst_n (rst_ok),
        .d     ({s_dtack[i], s_irq[i]}),
        .q     (hq)
      );
      assign ret_dtack[i] = hq[1];
      assign ret_irq[i]   = hq[0];
    end else begin : g_direct
      assign ret_dtack[i] = s_dtack[i];
      assign ret_irq[i]   = s_irq[i];
    end
  end

  // ---------------- internal default responder ----------------------------
  logic dflt_d, dflt_q, dflt_en;

  always_comb begin
    dflt_d  = miss;
    dflt_en = dflt_d ^ dflt_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      dflt_q <= 1'b0;
    end else if (dflt_en) begin
      dflt_q <= dflt_d;
    end
  end

  // ---------------- OR merge toward master --------------------------------
  logic [MW-1:0] rd_or;
  logic          ack_or, irq_or;

  always_comb begin
    rd_or  = '0;
    ack_or = dflt_q;
    irq_or = 1'b0;
    for (int i = 0; i < NS; i++) begin
      rd_or  = rd_or | lane_rdata[i*MW +: MW];
      ack_or = ack_or | ret_dtack[i];
      irq_or = irq_or | ret_irq[i];
    end
  end

  assign m_rdata = rd_or;
  assign m_dtack = ack_or && rst_ok;
  assign m_irq   = irq_or && rst_ok;

endmodule

// File: rtl/regbus_xbar_chk.sv
module regbus_xbar_chk #(
  parameter int              NS        = 3,
  parameter int              MW        = 32,
  parameter logic [NS*8-1:0] SLV_DW    = '0,
  parameter logic [NS-1:0]   SLV_ASYNC = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m_sel,
  input logic             m_dtack,
  input logic [NS-1:0]    s_sel,
  input logic [NS*MW-1:0] s_wdata,
  input logic [NS-1:0]    s_dtack
);

  // R1: never more than one slave selected
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_sel));

  // R1: a slave select implies a master cycle
  p_sel_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sel != '0) |-> m_sel);

  // R2: unmatched access is acknowledged one edge later
  p_dflt_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && (s_sel == '0)) |=> m_dtack);

  for (genvar i = 0; i < NS; i++) begin : g_chk
    localparam int SDW = int'(SLV_DW[i*8 +: 8]);
    if (SDW < MW) begin : g_narrow
      // R4: upper write lanes of a narrow slave stay zero
      p_wdata_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_wdata[i*MW + SDW +: (MW - SDW)] == '0);
    end
    if (!SLV_ASYNC[i]) begin : g_sync
      // R6: synchronous acknowledge reaches master in the same cycle
      p_sync_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_dtack[i] |-> m_dtack);
    end
  end

endmodule

bind regbus_xbar regbus_xbar_chk #(
  .NS        (NS),
  .MW        (MW),
  .SLV_DW    (SLV_DW),
  .SLV_ASYNC (SLV_ASYNC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_ok),
  .m_sel   (m_sel),
  .m_dtack (m_dtack),
  .s_sel   (s_sel),
  .s_wdata (s_wdata),
  .s_dtack (s_dtack)
);

// File: tb/regbus_xbar_test.sv
module regbus_xbar_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 3, AW = 16, MW = 32, SAW = 8;

  localparam int SIG_SEL = 0, SIG_ACK = 1, SIG_IRQ = 2, SIG_RD = 3,
                 SIG_SADDR = 4, SIG_SWD = 5, SIG_SREAD = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             m_sel, m_read;
  logic [AW-1:0]    m_addr;
  logic [MW-1:0]    m_wdata;
  logic [MW-1:0]    m_rdata;
  logic             m_dtack, m_irq;
  logic [NS-1:0]    s_sel;
  logic             s_read;
  logic [NS*SAW-1:0] s_addr;
  logic [NS*MW-1:0] s_wdata;
  logic [NS*MW-1:0] s_rdata;
  logic [NS-1:0]    s_dtack, s_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regbus_xbar uut (
    .clk (clk), .rst_n (rst_n),
    .m_sel (m_sel), .m_read (m_read), .m_addr (m_addr), .m_wdata (m_wdata),
    .m_rdata (m_rdata), .m_dtack (m_dtack), .m_irq (m_irq),
    .s_sel (s_sel), .s_read (s_read), .s_addr (s_addr), .s_wdata (s_wdata),
    .s_rdata (s_rdata), .s_dtack (s_dtack), .s_irq (s_irq)
  );

  typedef struct {
    string       req;
    int          sig;
    int          idx;
    logic [31:0] exp;
  } item_t;

  item_t queue_q[$];
  event  chk_ev;
  int    errors = 0;
  int    checks = 0;
  bit    done   = 1'b0;

  function automatic logic [31:0] actual(int sig, int idx);
    case (sig)
      SIG_SEL:   return 32'(s_sel);
      SIG_ACK:   return 32'(m_dtack);
      SIG_IRQ:   return 32'(m_irq);
      SIG_RD:    return m_rdata;
      SIG_SADDR: return 32'(s_addr[idx*SAW +: SAW]);
      SIG_SWD:   return s_wdata[idx*MW +: MW];
      default:   return 32'(s_read);
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (queue_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = queue_q.pop_front();
        act = actual(it.sig, it.idx);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sig=%0d idx=%0d actual=%h expected=%h",
                   it.req, it.sig, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, int sig, int idx, logic [31:0] exp);
    item_t it;
    it.req = req; it.sig = sig; it.idx = idx; it.exp = exp;
    queue_q.push_back(it);
  endtask

  task automatic compare_now();
    #1;
    -> chk_ev;
    #1;
  endtask

  task automatic next_neg();
    @(negedge clk);
  endtask

  task automatic idle_slaves();
    s_rdata = '0; s_dtack = '0; s_irq = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; m_sel = 1'b0; m_read = 1'b0; m_addr = '0; m_wdata = '0;
    s_rdata = '0; s_dtack = 3'b100; s_irq = 3'b100;

    // R9: reset with async slave holding its returns high
    repeat (3) next_neg();
    expect_val("R9", SIG_ACK, 0, 32'd0);
    expect_val("R9", SIG_IRQ, 0, 32'd0);
    expect_val("R1", SIG_SEL, 0, 32'd0);
    compare_now();
    idle_slaves();
    next_neg();
    rst_n = 1'b1;
    repeat (4) next_neg();

    // write to 8-bit slave at 0x0114
    m_sel = 1'b1; m_read = 1'b0; m_addr = 16'h0114; m_wdata = 32'hA5C3_5A7E;
    expect_val("R1", SIG_SEL, 0, 32'b010);
    expect_val("R5", SIG_SADDR, 1, 32'h05);
    expect_val("R4", SIG_SWD, 1, 32'h0000_007E);
    expect_val("R4", SIG_SWD, 2, 32'h0000_5A7E);
    expect_val("R4", SIG_SWD, 0, 32'hA5C3_5A7E);
    expect_val("R4", SIG_SREAD, 0, 32'd0);
    expect_val("R6", SIG_ACK, 0, 32'd0);
    compare_now();
    s_dtack = 3'b010;
    expect_val("R6", SIG_ACK, 0, 32'd1);
    compare_now();
    next_neg();
    m_sel = 1'b0; idle_slaves();
    next_neg();

    // read from async 16-bit slave at 0x0216
    m_sel = 1'b1; m_read = 1'b1; m_addr = 16'h0216;
    s_rdata[2*MW +: MW] = 32'hFFFF_1234; s_dtack = 3'b100;
    expect_val("R1", SIG_SEL, 0, 32'b100);
    expect_val("R5", SIG_SADDR, 2, 32'h0A);
    expect_val("R4", SIG_SREAD, 0, 32'd1);
    expect_val("R3", SIG_RD, 0, 32'h0000_1234);
    expect_val("R7", SIG_ACK, 0, 32'd0);
    compare_now();
    next_neg();
    expect_val("R7", SIG_ACK, 0, 32'd0);
    compare_now();
    next_neg();
    expect_val("R7", SIG_ACK, 0, 32'd1);
    compare_now();
    m_sel = 1'b0; idle_slaves();
    next_neg();
    expect_val("R7", SIG_ACK, 0, 32'd1);
    compare_now();
    next_neg();
    expect_val("R7", SIG_ACK, 0, 32'd0);
    compare_now();

    // 32-bit slave read, OR merge with junk from narrow slave
    m_sel = 1'b1; m_addr = 16'h003C;
    s_rdata[0*MW +: MW] = 32'hDEAD_BEEF;
    s_rdata[1*MW +: MW] = 32'hFFFF_FF10;
    s_dtack = 3'b001;
    expect_val("R5", SIG_SADDR, 0, 32'h3C);
    expect_val("R3", SIG_RD, 0, 32'hDEAD_BEFF);
    expect_val("R6", SIG_ACK, 0, 32'd1);
    compare_now();
    next_neg();
    m_sel = 1'b0; idle_slaves();
    next_neg();

    // region edges
    m_sel = 1'b0; m_addr = 16'h0100;
    expect_val("R1", SIG_SEL, 0, 32'd0);
    compare_now();
    m_sel = 1'b1; m_addr = 16'h013F;
    expect_val("R1", SIG_SEL, 0, 32'b010);
    expect_val("R5", SIG_SADDR, 1, 32'h0F);
    compare_now();

    // first byte past slave 0: unmapped, default responder
    m_addr = 16'h0040;
    expect_val("R1", SIG_SEL, 0, 32'd0);
    expect_val("R2", SIG_ACK, 0, 32'd0);
    compare_now();
    next_neg();
    expect_val("R2", SIG_ACK, 0, 32'd1);
    expect_val("R2", SIG_RD, 0, 32'd0);
    compare_now();
    m_sel = 1'b0;
    expect_val("R2", SIG_ACK, 0, 32'd1);
    compare_now();
    next_neg();
    expect_val("R2", SIG_ACK, 0, 32'd0);
    compare_now();

    // unmapped gap
    m_sel = 1'b1; m_addr = 16'h0400;
    next_neg();
    expect_val("R2", SIG_ACK, 0, 32'd1);
    compare_now();
    m_sel = 1'b0;
    next_neg();

    // interrupts
    s_irq = 3'b001;
    expect_val("R8", SIG_IRQ, 0, 32'd1);
    compare_now();
    s_irq = 3'b100;
    expect_val("R8", SIG_IRQ, 0, 32'd0);
    compare_now();
    next_neg();
    expect_val("R7", SIG_IRQ, 0, 32'd0);
    compare_now();
    next_neg();
    expect_val("R7", SIG_IRQ, 0, 32'd1);
    compare_now();
    idle_slaves();
    repeat (3) next_neg();
    expect_val("R8", SIG_IRQ, 0, 32'd0);
    compare_now();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule